// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer built around an 8-bit up-counter. The counter and its control register are guarded by a key. Both are written through one shared bus address. Only full 16-bit word writes are accepted. The upper byte of the word acts as a key that picks the target register, and the lower byte carries the value. Byte-sized writes, and words carrying an unknown key, change nothing. While the enable bit in the control register is set, a fixed prescaler advances the counter. When the counter wraps from 0xFF to 0x00, an overflow is raised.

An overflow sets a sticky flag in a reset-control register and starts a fixed-length internal reset pulse. A bit in the same register decides whether that pulse also drives an external reset output. The reset pulse comes from a two-state machine. The state `RS_IDLE` moves to `RS_PULSE` when an overflow arrives. The state `RS_PULSE` returns to `RS_IDLE` after `RST_CYCLES` clocks in that state. An overflow that arrives while the machine is in `RS_PULSE` does not restart or extend the pulse.

Reads are combinational. The counter and the control register sit at separate read addresses, because the shared write address cannot tell them apart.

Top module: `wdog_keyed`

## Requirements
- R1: A word write (`bus_word`=1) to address 0 whose upper byte is 0x5A loads the lower byte into the counter on the next clock edge. The counter reads back at address 1.
- R2: A word write to address 0 whose upper byte is 0xA5 loads the lower byte into the control register, which reads back at address 0. Bit 5 of this register is the timer enable.
- R3: A write with `bus_word`=0 changes no register, whatever its address, key or data.
- R4: A word write whose key does not match, or that goes to an address that accepts no writes (address 1), leaves the counter and the control register unchanged.
- R5: While the enable bit is 1, the counter rises by one every `PRESC_DIV` (default 4) clocks. While it is 0, the counter holds and the prescaler restarts from zero.
- R6: An increment from 0xFF wraps the counter to 0x00 and registers an overflow. On the next edge, bit 7 (the flag) of the reset-control register (read at address 2) becomes 1. From that edge, `rst_int_o` is high for exactly `RST_CYCLES` (default 16) clocks.
- R7: `rst_ext_o` is high only while `rst_int_o` is high and bit 6 of reset-control is 1. Bit 6 resets to 0 and is loaded from `bus_wdata[6]` by a word write to address 2 with key 0x5A.
- R8: Bits 5..0 of reset-control always read as 1.
- R9: The overflow flag is cleared only by a word write to address 2 with key 0xA5 and `bus_wdata[7]`=0. A new overflow in the same cycle wins over the clear.
- R10: When a keyed counter write coincides with a prescaler tick, the written value is kept, and no overflow is raised even if the counter held 0xFF.
- R11: `bus_rdata` is 0 when `bus_rd` is low or the address is not 0, 1 or 2.
- R12: After reset, the counter and the control register are 0, reset-control reads 0x3F, and both reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write word: key in bits 15..8, value in bits 7..0 |
| bus_word | input | 1 | 1 marks a 16-bit transfer, 0 a byte transfer |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset output |

## Verification
The sharpest collision is a keyed counter write landing on the same edge as a prescaler tick while the counter holds 0xFF. Here a load and a wrap compete for the same register. The bench provokes it by loading 0xFF and enabling the timer. It then watches its own prescaler phase and drives the write exactly on the clock before a tick is due. It judges the result by the loaded value appearing on the counter, by the overflow flag staying clear, and by no reset pulse following. A cycle-by-cycle behavioural model also checks the reset outputs and the read data on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_CNT = 8'h5A;
    localparam logic [7:0] KEY_CTL = 8'hA5;

    localparam int ADDR_SHARED = 0;
    localparam int ADDR_CNT_RD = 1;
    localparam int ADDR_RCTL   = 2;

    localparam int TEN_BIT  = 5;
    localparam int EXT_BIT  = 6;
    localparam int FLAG_BIT = 7;

    typedef enum logic [0:0] {
        RS_IDLE  = 1'b0,
        RS_PULSE = 1'b1
    } rst_state_e;

endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        key_byte,
    input  logic              flag_bit,
    input  logic              bus_word,
    input  logic              bus_wr,
    output logic              we_cnt,
    output logic              we_ctl,
    output logic              we_ext,
    output logic              clr_flag
);

    logic word_wr;
    logic at_shared;
    logic at_rctl;

    always_comb begin
        word_wr   = bus_wr && bus_word;
        at_shared = (bus_addr == ADDR_W'(ADDR_SHARED));
        at_rctl   = (bus_addr == ADDR_W'(ADDR_RCTL));
        we_cnt    = word_wr && at_shared && (key_byte == KEY_CNT);
        we_ctl    = word_wr && at_shared && (key_byte == KEY_CTL);
        we_ext    = word_wr && at_rctl   && (key_byte == KEY_CNT);
        clr_flag  = word_wr && at_rctl   && (key_byte == KEY_CTL) && !flag_bit;
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int PRESC_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ten,
    input  logic       we_cnt,
    input  logic [7:0] wdata_lo,
    output logic [7:0] cnt_o,
    output logic       ovf_o
);

    localparam int PRE_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [7:0]       cnt_q;
    logic             ovf_q;
    logic             tick;

    always_comb begin
        tick = ten && (pre_q == PRE_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!ten || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= tick && (cnt_q == 8'hFF) && !we_cnt;
            if (we_cnt) begin
                cnt_q <= wdata_lo;
            end else if (tick) begin
                cnt_q <= cnt_q + 8'd1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ten && !we_cnt) |=> $stable(cnt_q));

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_cnt |=> (!ovf_q && cnt_q == $past(wdata_lo)));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == 8'h00));

endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ext_en,
    output logic rst_int_o,
    output logic rst_ext_o
);

    localparam int PC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RST_CYCLES - 1);

    rst_state_e    state_q;
    rst_state_e    state_d;
    logic [PC_W-1:0] pc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (ovf) state_d = RS_PULSE;
            RS_PULSE: if (pc_q == PC_LAST) state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= (state_q == RS_PULSE && state_d == RS_PULSE) ? pc_q + 1'b1 : '0;
        end
    end

    always_comb begin
        rst_int_o = (state_q == RS_PULSE);
        rst_ext_o = (state_q == RS_PULSE) && ext_en;
    end

    // R6
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && ovf) |=> rst_int_o);

    // R6
    pulse_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_int_o) |-> (pc_q == '0));

    // R7
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ext_o |-> rst_int_o);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PRESC_DIV  = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_word,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              rst_int_o,
    output logic              rst_ext_o
);

    logic       we_cnt;
    logic       we_ctl;
    logic       we_ext;
    logic       clr_flag;
    logic [7:0] ctrl_q;
    logic       ext_q;
    logic       flag_q;
    logic [7:0] cnt_val;
    logic       ovf;

    wdt_keygate #(.ADDR_W(ADDR_W)) u_gate (
        .bus_addr (bus_addr),
        .key_byte (bus_wdata[15:8]),
        .flag_bit (bus_wdata[FLAG_BIT]),
        .bus_word (bus_word),
        .bus_wr   (bus_wr),
        .we_cnt   (we_cnt),
        .we_ctl   (we_ctl),
        .we_ext   (we_ext),
        .clr_flag (clr_flag)
    );

    wdt_count #(.PRESC_DIV(PRESC_DIV)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ten      (ctrl_q[TEN_BIT]),
        .we_cnt   (we_cnt),
        .wdata_lo (bus_wdata[7:0]),
        .cnt_o    (cnt_val),
        .ovf_o    (ovf)
    );

    wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf       (ovf),
        .ext_en    (ext_q),
        .rst_int_o (rst_int_o),
        .rst_ext_o (rst_ext_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ext_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (we_ctl) ctrl_q <= bus_wdata[7:0];
            if (we_ext) ext_q  <= bus_wdata[EXT_BIT];
            if (ovf) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(ADDR_SHARED): bus_rdata = ctrl_q;
                ADDR_W'(ADDR_CNT_RD): bus_rdata = cnt_val;
                ADDR_W'(ADDR_RCTL):   bus_rdata = {flag_q, ext_q, 6'h3F};
                default:              bus_rdata = 8'h00;
            endcase
        end
    end

    // R3
    byte_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word) |=> ($stable(ctrl_q) && $stable(ext_q)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_flag) |=> flag_q);

    // R8
    rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(ADDR_RCTL)) |-> (bus_rdata[5:0] == 6'h3F));

endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;

    localparam int AW  = 4;
    localparam int DIV = 4;
    localparam int RC  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_word = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic          rst_int_o;
    logic          rst_ext_o;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int m_cnt, m_ctrl, m_pre, m_pc;
    bit m_ext, m_flag, m_ovf, m_pulse;

    always #2.5 clk = ~clk;

    wdog_keyed #(.ADDR_W(AW), .PRESC_DIV(DIV), .RST_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
    );

    function automatic int model_read(int a, bit rd);
        if (!rd) return 0;
        if (a == 0) return m_ctrl;
        if (a == 1) return m_cnt;
        if (a == 2) return (int'(m_flag) << 7) | (int'(m_ext) << 6) | 'h3F;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_pre = 0; m_pc = 0;
            m_ext = 0; m_flag = 0; m_ovf = 0; m_pulse = 0;
        end else begin
            bit ww, tick, wc, wt, we, clr, ovf_old;
            ww   = bus_wr && bus_word;
            wc   = ww && bus_addr == 0 && bus_wdata[15:8] == 8'h5A;
            wt   = ww && bus_addr == 0 && bus_wdata[15:8] == 8'hA5;
            we   = ww && bus_addr == 2 && bus_wdata[15:8] == 8'h5A;
            clr  = ww && bus_addr == 2 && bus_wdata[15:8] == 8'hA5 && !bus_wdata[7];
            tick = m_ctrl[5] && m_pre == DIV - 1;
            ovf_old = m_ovf;
            m_ovf = tick && m_cnt == 255 && !wc;
            if (!m_ctrl[5] || tick) m_pre = 0; else m_pre = m_pre + 1;
            if (wc) m_cnt = bus_wdata[7:0];
            else if (tick) m_cnt = (m_cnt + 1) % 256;
            if (m_pulse) begin
                if (m_pc == RC - 1) begin m_pulse = 0; m_pc = 0; end
                else m_pc = m_pc + 1;
            end else if (ovf_old) begin
                m_pulse = 1; m_pc = 0;
            end
            if (ovf_old) m_flag = 1; else if (clr) m_flag = 0;
            if (wt) m_ctrl = bus_wdata[7:0];
            if (we) m_ext = bus_wdata[6];
        end
    end

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (rst_int_o !== m_pulse) begin
                bad++;
                $display("FAIL R6 rst_int_o act=%0b exp=%0b", rst_int_o, m_pulse);
            end
            total++;
            if (rst_ext_o !== (m_pulse && m_ext)) begin
                bad++;
                $display("FAIL R7 rst_ext_o act=%0b exp=%0b", rst_ext_o, m_pulse && m_ext);
            end
            total++;
            if (bus_rdata !== 8'(model_read(int'(bus_addr), bus_rd))) begin
                bad++;
                $display("FAIL R11 rdata act=%02h exp=%02h", bus_rdata,
                         8'(model_read(int'(bus_addr), bus_rd)));
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d, bit word);
        @(negedge clk); #1;
        bus_rd = 0; bus_addr = AW'(a); bus_wdata = 16'(d); bus_word = word; bus_wr = 1;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk); #1;
        bus_addr = AW'(a); bus_rd = 1;
        #1;
        v = int'(bus_rdata);
    endtask

    int v, v0, hi, hi_ext, bad_seen;

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;

        // R12 reset state, R8 reserved ones
        chk("R12 out", int'(rst_int_o) + int'(rst_ext_o), 0);
        rd(0, v); chk("R12 ctrl", v, 0);
        rd(1, v); chk("R12 cnt", v, 0);
        rd(2, v); chk("R8 rctl", v, 'h3F);

        // R1 keyed counter load
        wr(0, 'h5A37, 1);
        rd(1, v); chk("R1 cnt", v, 'h37);

        // R3 byte writes ignored
        wr(0, 'h5A12, 0);
        rd(1, v); chk("R3 cnt", v, 'h37);
        wr(0, 'hA5FF, 0);
        rd(0, v); chk("R3 ctrl", v, 0);

        // R4 wrong key / wrong address
        wr(0, 'h3311, 1);
        rd(1, v); chk("R4 cnt", v, 'h37);
        rd(0, v); chk("R4 ctrl", v, 0);
        wr(1, 'h5A99, 1);
        rd(1, v); chk("R4 cnt addr1", v, 'h37);

        // R2 control load, R5 counting
        wr(0, 'hA520, 1);
        rd(0, v); chk("R2 ctrl", v, 'h20);
        repeat (40) @(negedge clk);
        rd(1, v); chk("R5 count", v, m_cnt);
        chk("R5 advanced", int'(v >= 'h37 + 9), 1);

        // R5 hold when disabled
        wr(0, 'hA500, 1);
        rd(1, v0);
        repeat (20) @(negedge clk);
        rd(1, v); chk("R5 hold", v, v0);

        // R7 external enable, R8
        wr(2, 'h5A40, 1);
        rd(2, v); chk("R7 rctl", v, 'h7F);

        // R6 overflow with external output
        wr(0, 'h5AFE, 1);
        wr(0, 'hA520, 1);
        bus_rd = 0;
        for (int i = 0; i < 200 && !rst_int_o; i++) @(negedge clk);
        hi = 0; hi_ext = 0;
        while (rst_int_o && hi < 100) begin
            hi++;
            if (rst_ext_o) hi_ext++;
            @(negedge clk);
        end
        chk("R6 pulse len", hi, RC);
        chk("R7 ext len", hi_ext, RC);
        rd(2, v); chk("R6 flag", v, 'hFF);

        // R9 flag clearing rules
        wr(2, 'hA5C0, 1);
        rd(2, v); chk("R9 bit7 one", v, 'hFF);
        wr(2, 'h3300, 1);
        rd(2, v); chk("R9 bad key", v, 'hFF);
        wr(2, 'hA500, 0);
        rd(2, v); chk("R9 byte", v, 'hFF);
        wr(2, 'h5A00, 1);
        rd(2, v); chk("R7 ext off", v, 'hBF);
        wr(2, 'hA500, 1);
        rd(2, v); chk("R9 clear", v, 'h3F);

        // R10 counter write on the tick edge at 0xFF
        wr(0, 'hA500, 1);
        wr(0, 'h5AFF, 1);
        wr(0, 'hA520, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (m_pre == DIV - 1) break;
        end
        chk("R10 phase", m_pre * 256 + m_cnt, (DIV - 1) * 256 + 255);
        #1;
        bus_rd = 0; bus_addr = 0; bus_wdata = 16'h5A10; bus_word = 1; bus_wr = 1;
        @(negedge clk); #1;
        bus_wr = 0;
        bad_seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (rst_int_o) bad_seen = 1;
            @(negedge clk);
        end
        chk("R10 no pulse", bad_seen, 0);
        rd(2, v); chk("R10 no flag", v, 'h3F);
        rd(1, v); chk("R10 cnt", v, m_cnt);
        chk("R10 loaded", int'(v >= 'h10 && v < 'h18), 1);

        // R7 external output stays low when disabled
        bus_rd = 0;
        for (int i = 0; i < 1500 && !rst_int_o; i++) @(negedge clk);
        hi = 0; hi_ext = 0;
        while (rst_int_o && hi < 100) begin
            hi++;
            if (rst_ext_o) hi_ext++;
            @(negedge clk);
        end
        chk("R6 second pulse", hi, RC);
        chk("R7 ext masked", hi_ext, 0);
        rd(2, v); chk("R6 flag ext off", v, 'hBF);

        // R11 read gating
        rd(3, v); chk("R11 unmapped", v, 0);
        @(negedge clk); #1;
        bus_addr = 1; bus_rd = 0; #1;
        chk("R11 no rd", int'(bus_rdata), 0);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule